// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds the colour table of an 8-bit indexed framebuffer: 256 entries, each with an 8-bit red, green and blue value. Software programs the table over a small memory-mapped slave. It first writes a start entry number to an index register. It then streams colour bytes into a data register: red, then green, then blue for one entry. After each blue byte the block moves on to the following entry by itself, so a whole table loads as one run of data writes.

Each colour byte comes from the most significant byte of the 32-bit bus word. A separate lookup port lets the pixel pipeline read any entry as packed 24-bit RGB, with one clock of latency. The bus never stalls, and every read of the register window returns zero.

Top module: `clut_loader`

## Requirements
- R1: The register number is bits 3:2 of the 4-bit byte address, and bits 1:0 are ignored. Register 0 is the index register and register 1 is the colour data register.
- R2: A write to register 0 loads the current entry index from write data bits 31:24. It also restarts the component sequence at red, even partway through an entry.
- R3: Successive writes to register 1 store write data bits 31:24 into the red, green and blue components of the current entry, in that order.
- R4: The blue write advances the index by one modulo 256, so entry 255 is followed by entry 0, and the sequence returns to red.
- R5: A component write changes only that one component of the indexed entry. A lookup issued in the cycle after the write returns the new value.
- R6: After reset, entries 0 to 254 read as black (0x000000), entry 255 reads as white (0xFFFFFF), and the lookup output is 0.
- R7: bus_rdata is always zero. A bus cycle with bus_write low changes neither the index nor the sequence.
- R8: Writes to registers 2 and 3 are ignored. Index, sequence and table contents stay unchanged.
- R9: The lookup output is registered. The entry selected by lut_idx in one cycle appears on lut_rgb after the next rising edge, packed as red in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address within the register window |
| bus_wdata | input | 32 | Write data; the colour or index byte is in bits 31:24 |
| bus_rdata | output | 32 | Read data, always zero |
| lut_idx | input | 8 | Entry selected for lookup |
| lut_rgb | output | 24 | Registered lookup result {R,G,B} |

## Verification
The bench builds the block with its default parameters: 8-bit index, 8-bit components, a 32-bit bus and a 4-bit address. With 256 entries, the wrap from entry 255 to entry 0 and the preset white last entry are reached in a few bus writes. Because of that, both ends of the table, aliased addresses and sequences cut short by index writes or spare-register writes are all covered in a short run.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int COMP_W  = 8;
    localparam int IDX_W   = 8;
    localparam int NUM_ENT = 1 << IDX_W;
    localparam int RGB_W   = 3 * COMP_W;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RG_INDEX   = 2'd0,
        RG_COLOUR  = 2'd1,
        RG_SPARE_A = 2'd2,
        RG_SPARE_B = 2'd3
    } reg_e;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        phase_e            comp;
        logic [COMP_W-1:0] val;
    } comp_wr_t;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

    function automatic rgb_t merge_comp(rgb_t cur, phase_e c, logic [COMP_W-1:0] v);
        rgb_t n;
        n = cur;
        case (c)
            PH_RED:   n.r = v;
            PH_GREEN: n.g = v;
            default:  n.b = v;
        endcase
        return n;
    endfunction

    function automatic rgb_t reset_entry(int e);
        rgb_t n;
        n = (e == NUM_ENT - 1) ? '1 : '0;
        return n;
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output comp_wr_t          wr
);
    localparam int TOP_LSB = DATA_W - COMP_W;

    reg_e              rsel;
    logic [COMP_W-1:0] top_byte;
    logic              wr_go;
    logic [IDX_W-1:0]  idx_q;
    phase_e            phase_q;
    logic              addr_unused;
    logic              wdata_unused;

    assign rsel         = reg_e'(bus_addr[3:2]);
    assign top_byte     = bus_wdata[DATA_W-1:TOP_LSB];
    assign wr_go        = bus_valid && bus_write;
    assign addr_unused  = ^bus_addr[1:0];
    assign wdata_unused = ^bus_wdata[TOP_LSB-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            phase_q <= PH_RED;
        end else if (wr_go) begin
            case (rsel)
                RG_INDEX: begin
                    idx_q   <= top_byte;
                    phase_q <= PH_RED;
                end
                RG_COLOUR: begin
                    phase_q <= next_phase(phase_q);
                    if (phase_q == PH_BLUE) idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr.en   = wr_go && (rsel == RG_COLOUR);
        wr.idx  = idx_q;
        wr.comp = phase_q;
        wr.val  = top_byte;
    end

    AST_INDEX_RESTARTS_RED: assert property (@(posedge clk) disable iff (rst)
        (wr_go && rsel == RG_INDEX) |=> (phase_q == PH_RED && idx_q == $past(top_byte))); // R2
    AST_RED_THEN_GREEN: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.comp == PH_RED) |=> (phase_q == PH_GREEN && $stable(idx_q))); // R3
    AST_BLUE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.comp == PH_BLUE) |=> (phase_q == PH_RED && idx_q == $past(idx_q) + 1'b1)); // R4
    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> ($stable(idx_q) && $stable(phase_q))); // R7
    AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_go && bus_addr[3]) |=> ($stable(idx_q) && $stable(phase_q))); // R8
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        phase_q != 2'd3); // R3

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  comp_wr_t         wr,
    input  logic [IDX_W-1:0] rd_idx,
    output rgb_t             rd_rgb
);
    rgb_t [NUM_ENT-1:0] ent;
    logic [NUM_ENT-1:0] hit;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_hit
        assign hit[e] = wr.en && (wr.idx == IDX_W'(e));
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_ENT; e++) begin
            if (rst)         ent[e] <= reset_entry(e);
            else if (hit[e]) ent[e] <= merge_comp(ent[e], wr.comp, wr.val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_rgb <= '0;
        else     rd_rgb <= ent[rd_idx];
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R5
    AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(ent)); // R5
    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_rgb == $past(ent[rd_idx]))); // R9

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  lut_idx,
    output logic [RGB_W-1:0]  lut_rgb
);
    comp_wr_t wr;
    rgb_t     rd_rgb;

    clut_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr        (wr)
    );

    clut_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_idx (lut_idx),
        .rd_rgb (rd_rgb)
    );

    assign bus_rdata = '0;
    assign lut_rgb   = rd_rgb;

endmodule

// File: tb/clut_loader_tb.sv
`timescale 1ns/1ps
module clut_loader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [23:0] model [256];
    int          m_idx = 0;
    int          m_ph = 0;

    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    clut_loader u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one bus write per cycle, model updated for the coming edge
    task automatic bw(logic [3:0] a, logic [7:0] b, logic [23:0] low);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = {b, low};
        case (a[3:2])
            2'd0: begin m_idx = b; m_ph = 0; end
            2'd1: begin
                case (m_ph)
                    0: model[m_idx][23:16] = b;
                    1: model[m_idx][15:8]  = b;
                    default: model[m_idx][7:0] = b;
                endcase
                if (m_ph == 2) begin m_idx = (m_idx + 1) % 256; m_ph = 0; end
                else m_ph++;
            end
            default: ;
        endcase
    endtask

    task automatic br(logic [3:0] a, string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = 32'hA5A5_A5A5;
        #1 check(req, bus_rdata, 32'h0);
    endtask

    // driver for lookups: expected item pushed for the monitor
    task automatic lk(int i, string req);
        @(negedge clk);
        bus_valid = 1'b0;
        lut_idx = 8'(i);
        exp_q.push_back(model[i]);
        tag_q.push_back(req);
    endtask

    task automatic lat_chk(int i);
        logic [23:0] prev;
        @(negedge clk);
        bus_valid = 1'b0;
        prev = lut_rgb;
        lut_idx = 8'(i);
        #1 check("R9 output holds before edge", {8'h0, lut_rgb}, {8'h0, prev});
        exp_q.push_back(model[i]);
        tag_q.push_back("R9 registered lookup");
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_valid = 1'b0;
        end
    endtask

    // monitor: pops one expectation per cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {8'h0, lut_rgb}, {8'h0, e});
            end
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) model[k] = (k == 255) ? 24'hFFFFFF : 24'h0;
        repeat (3) @(negedge clk);
        #1 check("R6 lookup output in reset", {8'h0, lut_rgb}, 32'h0);
        rst = 1'b0;
        lk(0, "R6 entry 0 black");
        lk(1, "R6 entry 1 black");
        lk(128, "R6 entry 128 black");
        lk(254, "R6 entry 254 black");
        lk(255, "R6 entry 255 white");

        // R3: basic R,G,B load into entry 10; low bits of data ignored
        bw(4'h0, 8'd10, 24'hFFFFFF);
        bw(4'h4, 8'h11, 24'h123456);
        bw(4'h4, 8'h22, 24'h0);
        bw(4'h4, 8'h33, 24'hABCDEF);
        lk(10, "R3 entry 10 rgb");   // issued the cycle after blue write
        lk(9, "R5 neighbour 9 untouched");
        lk(11, "R5 neighbour 11 untouched");

        // R4: continues into entry 11 without a new index write
        bw(4'h4, 8'h44, 24'h0);
        bw(4'h4, 8'h55, 24'h0);
        bw(4'h4, 8'h66, 24'h0);
        lk(11, "R4 auto-increment to 11");

        // R5: partial update visible at once, other components kept
        bw(4'h0, 8'd10, 24'h0);
        bw(4'h4, 8'h99, 24'h0);
        lk(10, "R5 red only changed, visible next cycle");

        // R4: wrap 255 -> 0
        bw(4'h0, 8'hFF, 24'h0);
        bw(4'h4, 8'h01, 24'h0);
        bw(4'h4, 8'h02, 24'h0);
        bw(4'h4, 8'h03, 24'h0);
        bw(4'h4, 8'h04, 24'h0);
        bw(4'h4, 8'h05, 24'h0);
        bw(4'h4, 8'h06, 24'h0);
        lk(255, "R4 entry 255 loaded");
        lk(0, "R4 wrapped to entry 0");

        // R1 + R2: aliased addresses, index write mid-sequence restarts at red
        bw(4'h3, 8'h20, 24'h0);
        bw(4'h6, 8'h77, 24'h0);
        bw(4'h1, 8'h21, 24'h0);
        bw(4'h7, 8'hA1, 24'h0);
        bw(4'h5, 8'hA2, 24'h0);
        bw(4'h4, 8'hA3, 24'h0);
        lk(32, "R2 partial entry 0x20 red only");
        lk(33, "R1 aliased addresses load entry 0x21");
        lk(34, "R2 entry 0x22 untouched");

        // R8: spare registers ignored mid-sequence
        bw(4'h0, 8'h40, 24'h0);
        bw(4'h4, 8'hB1, 24'h0);
        bw(4'h8, 8'hEE, 24'hEEEEEE);
        bw(4'hC, 8'h41, 24'h0);
        bw(4'hB, 8'hDD, 24'h0);
        bw(4'h4, 8'hB2, 24'h0);
        bw(4'h4, 8'hB3, 24'h0);
        bw(4'h4, 8'hC1, 24'h0);
        lk(64, "R8 entry 0x40 intact after spare writes");
        lk(65, "R8 sequence moved to 0x41 only via blue");
        lk(238, "R8 spare data not stored");

        // R7: reads return zero and do not advance the sequence
        br(4'h0, "R7 read reg0 zero");
        bw(4'h0, 8'h50, 24'h0);
        bw(4'h4, 8'hC5, 24'h0);
        br(4'h4, "R7 read reg1 zero");
        br(4'h8, "R7 read reg2 zero");
        br(4'hC, "R7 read reg3 zero");
        bw(4'h4, 8'hC6, 24'h0);
        bw(4'h4, 8'hC7, 24'h0);
        lk(80, "R7 reads did not disturb sequence");
        lk(81, "R7 entry 0x51 untouched");

        // R9: latency and packing
        lat_chk(10);
        lat_chk(255);
        lat_chk(80);
        idle(4);
        check("R9 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule